// File: doc/BRIEF.md
# Per-Processor Interrupt Presenter

This block sits in front of a single processor and decides which interrupt that processor sees. External sources raise level requests, and each request carries a 24-bit vector and an 8-bit priority. Software can also post an inter-processor request through a one-byte register. That request competes on the fixed vector 2. A lower priority number is more favoured. The block compares the most favoured pending candidate against the processor's current priority. It drives a level interrupt line while that candidate is strictly more favoured.

Software works through a four-word, big-endian register window. Byte lane enable `bus_be[3]` selects bits 31..24, which is the byte at the lowest address of the word. The acknowledge word puts the processor's current priority in bits 31..24 and the presented vector in bits 23..0. Reading the acknowledge word accepts the interrupt and raises the processor's priority to that of the accepted source. Writing the word back ends the interrupt and restores the priority held in its top byte. A separate poll copy of the word shows the same value without any side effect.

Top module: `irq_presenter`

## Requirements
- R1: After reset the current priority is 0x00, the inter-processor byte is 0xFF, `irq_out` is low and `eoi_valid` is low.
- R2: Among pending external sources, the one with the lowest priority number is selected. On equal priority the lowest source index wins.
- R3: `irq_out` is high exactly when the selected candidate's priority is strictly lower than the current priority. A current priority of 0x00 therefore blocks everything, and a source at priority 0xFF is never presented.
- R4: A read at byte offset 4 returns {current priority, vector}, with vector 0 when nothing is presented. If an interrupt was presented, the current priority becomes that source's priority from the next cycle on. A read that returns vector 0 changes no state.
- R5: A read at byte offset 0 returns the same word as offset 4 and changes no state.
- R6: A write at offset 4 with only `bus_be[3]` set loads bits 31..24 into the current priority and produces no end-of-interrupt.
- R7: A write at offset 4 with all four byte enables loads bits 31..24 into the current priority. In the cycle after the write it pulses `eoi_valid` for one cycle, with `eoi_vec` equal to bits 23..0.
- R8: A write at offset 12 with `bus_be[3]` set loads bits 31..24 into the inter-processor byte. Any value other than 0xFF posts a request on vector 2 at that priority, and 0xFF withdraws it. A read at offset 12 returns {byte, 24'h0}.
- R9: When the inter-processor request and the best external source have equal priority, vector 2 is presented.
- R10: Offset 8 reads as zero and ignores writes. At offset 4, byte-enable patterns other than 4'b1000 and 4'b1111 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_req | input | N_SRC | Level request per external source |
| src_vec | input | N_SRC*24 | Vector per source, source i at bits [24*i +: 24] |
| src_prio | input | N_SRC*8 | Priority per source, source i at bits [8*i +: 8] |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the word (0, 4, 8, 12) |
| bus_be | input | 4 | Byte enables, bit 3 = bits 31..24 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq_out | output | 1 | Interrupt level to the processor |
| eoi_valid | output | 1 | One-cycle end-of-interrupt pulse |
| eoi_vec | output | 24 | Vector being ended |

## Verification
The bench builds the block with its default of four external sources. Four sources are enough to set up a priority tie among external sources and a tie between an external source and the inter-processor request at the same time. They also let a more favoured source arrive while another one is accepted. In that configuration the bench can reach strict-versus-equal comparisons against the current priority, the 0x00 and 0xFF priority limits, acknowledge with and without a presented source, and the ignored byte-enable patterns.

// File: rtl/irqp_pkg.sv
package irqp_pkg;
  localparam int VEC_W  = 24;
  localparam int PRIO_W = 8;
  localparam int WORD_W = VEC_W + PRIO_W;

  localparam logic [VEC_W-1:0]  IPI_VEC   = 24'd2;
  localparam logic [PRIO_W-1:0] PRIO_NONE = 8'hFF;
  localparam logic [PRIO_W-1:0] PRIO_RST  = 8'h00;

  localparam logic [1:0] WIDX_POLL = 2'd0;
  localparam logic [1:0] WIDX_ACK  = 2'd1;
  localparam logic [1:0] WIDX_RSVD = 2'd2;
  localparam logic [1:0] WIDX_IPI  = 2'd3;

  localparam logic [3:0] BE_TOP  = 4'b1000;
  localparam logic [3:0] BE_WORD = 4'b1111;

  typedef struct packed {
    logic              valid;
    logic [PRIO_W-1:0] prio;
    logic [VEC_W-1:0]  vec;
  } cand_t;
endpackage

// File: rtl/irqp_rst_sync.sv
module irqp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/irqp_arbiter.sv
module irqp_arbiter
  import irqp_pkg::*;
#(
  parameter int N_SRC = 4
) (
  input  logic [N_SRC-1:0]        src_req,
  input  logic [N_SRC*VEC_W-1:0]  src_vec,
  input  logic [N_SRC*PRIO_W-1:0] src_prio,
  input  logic [PRIO_W-1:0]       ipi_prio,
  output cand_t                   best
);
  cand_t cand [N_SRC];

  for (genvar g = 0; g < N_SRC; g++) begin : g_unpack
    assign cand[g].valid = src_req[g];
    assign cand[g].prio  = src_prio[g*PRIO_W +: PRIO_W];
    assign cand[g].vec   = src_vec[g*VEC_W +: VEC_W];
  end

  // Inter-processor request enters first; strict compare keeps it on ties,
  // and keeps the lower index among equal external sources.
  always_comb begin
    best.valid = (ipi_prio != PRIO_NONE);
    best.prio  = ipi_prio;
    best.vec   = IPI_VEC;
    for (int i = 0; i < N_SRC; i++) begin
      if (cand[i].valid && (!best.valid || cand[i].prio < best.prio)) begin
        best = cand[i];
      end
    end
  end
endmodule

// File: rtl/irqp_state.sv
module irqp_state
  import irqp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_en,
  input  logic [PRIO_W-1:0] ack_prio,
  input  logic              cppr_wr_en,
  input  logic [PRIO_W-1:0] cppr_wdata,
  input  logic              eoi_en,
  input  logic [VEC_W-1:0]  eoi_wvec,
  input  logic              ipi_wr_en,
  input  logic [PRIO_W-1:0] ipi_wdata,
  output logic [PRIO_W-1:0] cppr_q,
  output logic [PRIO_W-1:0] ipi_q,
  output logic              eoi_valid_q,
  output logic [VEC_W-1:0]  eoi_vec_q
);
  logic [PRIO_W-1:0] cppr_d;
  logic [PRIO_W-1:0] ipi_d;
  logic              cppr_ce;
  logic              ipi_ce;

  always_comb begin
    cppr_ce = ack_en | cppr_wr_en;
    cppr_d  = ack_en ? ack_prio : cppr_wdata;
    ipi_ce  = ipi_wr_en;
    ipi_d   = ipi_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cppr_q      <= PRIO_RST;
      ipi_q       <= PRIO_NONE;
      eoi_valid_q <= 1'b0;
      eoi_vec_q   <= '0;
    end else begin
      if (cppr_ce) cppr_q    <= cppr_d;
      if (ipi_ce)  ipi_q     <= ipi_d;
      if (eoi_en)  eoi_vec_q <= eoi_wvec;
      eoi_valid_q <= eoi_en;
    end
  end
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
  import irqp_pkg::*;
#(
  parameter int N_SRC = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_SRC-1:0]        src_req,
  input  logic [N_SRC*VEC_W-1:0]  src_vec,
  input  logic [N_SRC*PRIO_W-1:0] src_prio,
  input  logic                    bus_en,
  input  logic                    bus_we,
  input  logic [3:0]              bus_addr,
  input  logic [3:0]              bus_be,
  input  logic [WORD_W-1:0]       bus_wdata,
  output logic [WORD_W-1:0]       bus_rdata,
  output logic                    irq_out,
  output logic                    eoi_valid,
  output logic [VEC_W-1:0]        eoi_vec
);
  logic              rst_sync_n;
  cand_t             best;
  logic [PRIO_W-1:0] cppr_q;
  logic [PRIO_W-1:0] ipi_q;
  logic [1:0]        widx;
  logic              rd_ack, wr_ack, cppr_wr, eoi_wr, ipi_wr;
  logic [PRIO_W-1:0] sel_prio;
  logic              sel_valid;
  logic [WORD_W-1:0] ack_word;

  irqp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irqp_arbiter #(.N_SRC(N_SRC)) u_arb (
    .src_req  (src_req),
    .src_vec  (src_vec),
    .src_prio (src_prio),
    .ipi_prio (ipi_q),
    .best     (best)
  );

  assign sel_prio  = best.prio;
  assign sel_valid = best.valid;
  assign irq_out   = best.valid && (best.prio < cppr_q);

  always_comb begin
    widx    = bus_addr[3:2];
    rd_ack  = bus_en && !bus_we && (widx == WIDX_ACK) && irq_out;
    wr_ack  = bus_en &&  bus_we && (widx == WIDX_ACK);
    cppr_wr = wr_ack && ((bus_be == BE_TOP) || (bus_be == BE_WORD));
    eoi_wr  = wr_ack && (bus_be == BE_WORD);
    ipi_wr  = bus_en && bus_we && (widx == WIDX_IPI) && bus_be[3];
  end

  always_comb begin
    ack_word = {cppr_q, irq_out ? best.vec : {VEC_W{1'b0}}};
    unique case (widx)
      WIDX_POLL, WIDX_ACK: bus_rdata = ack_word;
      WIDX_IPI:            bus_rdata = {ipi_q, {VEC_W{1'b0}}};
      default:             bus_rdata = '0;
    endcase
  end

  irqp_state u_state (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .ack_en      (rd_ack),
    .ack_prio    (best.prio),
    .cppr_wr_en  (cppr_wr),
    .cppr_wdata  (bus_wdata[WORD_W-1 -: PRIO_W]),
    .eoi_en      (eoi_wr),
    .eoi_wvec    (bus_wdata[VEC_W-1:0]),
    .ipi_wr_en   (ipi_wr),
    .ipi_wdata   (bus_wdata[WORD_W-1 -: PRIO_W]),
    .cppr_q      (cppr_q),
    .ipi_q       (ipi_q),
    .eoi_valid_q (eoi_valid),
    .eoi_vec_q   (eoi_vec)
  );
endmodule

// File: rtl/irq_presenter_chk.sv
module irq_presenter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_en,
  input logic        bus_we,
  input logic [3:0]  bus_addr,
  input logic [3:0]  bus_be,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        irq_out,
  input logic        eoi_valid,
  input logic [23:0] eoi_vec,
  input logic [7:0]  cppr_q,
  input logic [7:0]  ipi_q,
  input logic [7:0]  sel_prio
);
  // R4: an accepted read moves the current priority to the source's priority
  a_r4_ack_takes_prio: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && bus_addr == 4'd4 && irq_out) |=> (cppr_q == $past(sel_prio)));

  // R5: the poll read leaves all state alone
  a_r5_poll_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && bus_addr == 4'd0) |=> ($stable(cppr_q) && $stable(ipi_q)));

  // R7: a full-word write at offset 4 is followed by the pulse and its vector
  a_r7_eoi_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr == 4'd4 && bus_be == 4'hF)
      |=> (eoi_valid && eoi_vec == $past(bus_wdata[23:0])));

  // R7, R6: no pulse without a full-word write in the previous cycle
  a_r7_eoi_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid |-> $past(bus_en && bus_we && bus_addr == 4'd4 && bus_be == 4'hF));

  // R3: current priority 0 blocks every interrupt
  a_r3_zero_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cppr_q == 8'h00) |-> !irq_out);

  // R8: writing 0xFF withdraws the inter-processor request
  a_r8_ipi_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr == 4'd12 && bus_be[3] && bus_wdata[31:24] == 8'hFF)
      |=> (ipi_q == 8'hFF));

  // R10: the reserved word reads zero
  a_r10_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && bus_addr == 4'd8) |-> (bus_rdata == 32'h0));
endmodule

bind irq_presenter irq_presenter_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_en    (bus_en),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_be    (bus_be),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_out   (irq_out),
  .eoi_valid (eoi_valid),
  .eoi_vec   (eoi_vec),
  .cppr_q    (cppr_q),
  .ipi_q     (ipi_q),
  .sel_prio  (sel_prio)
);

// File: tb/irq_presenter_tb_top.sv
module irq_presenter_tb_top;
  localparam int N = 4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N-1:0]    src_req;
  logic [N*24-1:0] src_vec;
  logic [N*8-1:0]  src_prio;
  logic            bus_en, bus_we;
  logic [3:0]      bus_addr, bus_be;
  logic [31:0]     bus_wdata;
  logic [31:0]     bus_rdata;
  logic            irq_out, eoi_valid;
  logic [23:0]     eoi_vec;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [31:0] rd_exp_q[$];
  string       rd_tag_q[$];
  logic [23:0] eoi_exp_q[$];

  always #2 clk = ~clk;

  irq_presenter #(.N_SRC(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_vec(src_vec),
    .src_prio(src_prio), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out), .eoi_valid(eoi_valid),
    .eoi_vec(eoi_vec)
  );

  // Monitor: pops expected items and compares with what the design produces
  always @(negedge clk) begin
    if (rst_n && bus_en && !bus_we) begin
      n_chk++;
      if (rd_exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL monitor: read with no expected item, actual %h", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = rd_exp_q.pop_front();
        t = rd_tag_q.pop_front();
        if (bus_rdata !== e) begin
          n_bad++;
          $display("FAIL %s: rdata actual %h expected %h", t, bus_rdata, e);
        end
      end
    end
    if (rst_n && eoi_valid) begin
      n_chk++;
      if (eoi_exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R6/R10: unexpected eoi actual %h expected none", eoi_vec);
      end else begin
        logic [23:0] ev;
        ev = eoi_exp_q.pop_front();
        if (eoi_vec !== ev) begin
          n_bad++;
          $display("FAIL R7: eoi_vec actual %h expected %h", eoi_vec, ev);
        end
      end
    end
  end

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a; bus_be = 4'hF;
    rd_exp_q.push_back(e);
    rd_tag_q.push_back(t);
    @(posedge clk); #1;
    bus_en = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
    @(posedge clk); #1;
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    if (a == 4'd4 && be == 4'hF) eoi_exp_q.push_back(d[23:0]);
    @(posedge clk); #1;
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic set_src(input int i, input logic r, input logic [23:0] v, input logic [7:0] p);
    @(posedge clk); #1;
    src_req[i] = r;
    src_vec[i*24 +: 24] = v;
    src_prio[i*8 +: 8] = p;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    n_chk++;
    if (irq_out !== e) begin
      n_bad++;
      $display("FAIL %s: irq_out actual %b expected %b", t, irq_out, e);
    end
  endtask

  initial begin
    #(4 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; src_req = '0; src_vec = '0; src_prio = '1;
    bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_be = '0; bus_wdata = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    chk_irq(1'b0, "R1");
    n_chk++;
    if (eoi_valid !== 1'b0) begin
      n_bad++; $display("FAIL R1: eoi_valid actual %b expected 0", eoi_valid);
    end
    rd(4'd12, 32'hFF00_0000, "R1 ipi byte");
    rd(4'd0,  32'h0000_0000, "R1 poll");

    // R3: priority 0 blocks; R4 vector 0 when nothing presented
    set_src(0, 1'b1, 24'h123456, 8'h05);
    chk_irq(1'b0, "R3 cppr zero");
    rd(4'd0, 32'h0000_0000, "R4 nothing presented");

    // R6: byte write opens the gate, no eoi
    wr(4'd4, 4'b1000, 32'hFF00_0000);
    chk_irq(1'b1, "R6/R3");
    rd(4'd0, 32'hFF12_3456, "R5 poll");
    rd(4'd0, 32'hFF12_3456, "R5 poll repeat");
    chk_irq(1'b1, "R5");

    // R2: more favoured source, then tie by index
    set_src(1, 1'b1, 24'h0000AA, 8'h03);
    rd(4'd0, 32'hFF00_00AA, "R2 lower prio");
    set_src(2, 1'b1, 24'h0000BB, 8'h03);
    rd(4'd0, 32'hFF00_00AA, "R2 tie index");

    // R4 acknowledge
    rd(4'd4, 32'hFF00_00AA, "R4 ack");
    chk_irq(1'b0, "R4 equal prio not presented");
    rd(4'd0, 32'h0300_0000, "R4 cppr loaded");

    // R3 more favoured arrival
    set_src(3, 1'b1, 24'h777777, 8'h01);
    chk_irq(1'b1, "R3 favoured arrival");
    rd(4'd0, 32'h0377_7777, "R3 presented");

    // R7 end of interrupt
    wr(4'd4, 4'hF, 32'hFF00_00AA);
    rd(4'd0, 32'hFF77_7777, "R7 cppr restored");

    // R3 priority 0xFF never presented
    set_src(1, 1'b0, 24'h0, 8'hFF);
    set_src(2, 1'b0, 24'h0, 8'hFF);
    set_src(3, 1'b0, 24'h0, 8'hFF);
    set_src(0, 1'b1, 24'h000055, 8'hFF);
    chk_irq(1'b0, "R3 prio FF");
    rd(4'd0, 32'hFF00_0000, "R3 prio FF poll");

    // R8 inter-processor request
    wr(4'd12, 4'b1000, 32'h0400_0000);
    chk_irq(1'b1, "R8 ipi raise");
    rd(4'd0,  32'hFF00_0002, "R8 ipi vector");
    rd(4'd12, 32'h0400_0000, "R8 ipi readback");

    // R9 tie goes to inter-processor request
    set_src(1, 1'b1, 24'h0000CC, 8'h04);
    rd(4'd0, 32'hFF00_0002, "R9 ipi wins tie");
    set_src(1, 1'b1, 24'h0000CC, 8'h03);
    rd(4'd0, 32'hFF00_00CC, "R9 external more favoured");
    set_src(1, 1'b0, 24'h0, 8'hFF);

    // R8 withdraw
    wr(4'd12, 4'b1000, 32'hFF00_0000);
    chk_irq(1'b0, "R8 withdraw");
    rd(4'd0, 32'hFF00_0000, "R8 withdrawn poll");

    // R10 reserved word and ignored byte enables
    wr(4'd8, 4'hF, 32'h1234_5678);
    rd(4'd8, 32'h0000_0000, "R10 reserved");
    set_src(0, 1'b1, 24'h000099, 8'h10);
    wr(4'd4, 4'b0011, 32'h0000_0000);
    wr(4'd4, 4'b0100, 32'h00AB_0000);
    chk_irq(1'b1, "R10 ignored be");
    rd(4'd0, 32'hFF00_0099, "R10 cppr unchanged");

    // R3 priority 0 blocks again; R4 ack with nothing presented
    wr(4'd4, 4'b1000, 32'h0000_0000);
    chk_irq(1'b0, "R3 cppr zero again");
    rd(4'd4, 32'h0000_0000, "R4 empty ack");
    rd(4'd0, 32'h0000_0000, "R4 empty ack no change");

    repeat (3) @(posedge clk);
    n_chk++;
    if (eoi_exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R7: eoi pulses missing actual %0d expected 0", eoi_exp_q.size());
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    done = 1'b1;
    $finish;
  end
endmodule